// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the command logic of a 512-byte serial EEPROM behind an SPI mode-0 slave port. The system clock oversamples chip select, SCK, SI and the write-protect pin through synchronizers. A small state machine then decodes each frame: latch control, status read, status write, array read and array write. The array is a register memory that comes out of reset erased to 0xFF.

Writes to the array or to the status register are gated by three things: a write-enable latch, the write-protect pin and a two-bit protect field that fences off an upper part of the address space. An accepted write starts only when chip select rises right after a complete data byte. It then runs an emulated programming cycle of a set number of system clocks. While that cycle runs, only the status read is honoured. SO is driven only while read or status data is being shifted out. Otherwise the pad is released through `so_oe`.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 (latch clear, protect field 00, not busy), `so_oe` is low and every array location reads 0xFF.
- R2: A WRITE (0x02, or 0x0A when A8=1) or a status write (0x01) is refused, with no busy cycle and no change to memory or status, while the write-enable latch is clear.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, each taking effect on the eighth opcode bit. The latch reads back as status bit 1.
- R4: A WRITE frame is the opcode (A8 in opcode bit 3), then address A7..A0, then one data byte sent MSB first. A READ frame (0x03, or 0x0B with A8=1) followed by an address returns the stored byte MSB first.
- R5: Opcode 0x05 shifts out the status byte MSB first, with layout {0000, BP1, BP0, latch, busy}. It repeats the byte for as long as SCK keeps running, and SI is ignored after the opcode.
- R6: An accepted write sets busy (status bit 0). Busy clears WR_CYCLES system clocks later, and the write-enable latch clears automatically at the same moment.
- R7: While `wp_n` is low, array writes and status writes are refused.
- R8: The protect field refuses array writes in these ranges: 01 refuses 0x180–0x1FF, 10 refuses 0x100–0x1FF and 11 refuses 0x000–0x1FF. Addresses below the range are written normally. A status write sets the field from data bits 3:2.
- R9: A write is accepted only when chip select rises after exactly eight data bits. With fewer or more bits the frame is dropped: nothing is programmed and busy stays 0.
- R10: While busy, every opcode except 0x05 is ignored. A READ does not drive SO and a WRITE does not change memory.
- R11: `so_oe` is low while chip select is high and during the opcode and address bits. SI is taken on the SCK rising edge and SO changes after the SCK falling edge.
- R12: A READ continues with the next address while SCK keeps running, and wraps from 0x1FF to 0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out, valid while so_oe is high |
| so_oe | output | 1 | Output enable for the SO pad driver |

## Verification
Every pin passes through two synchronizer stages and one edge register. A decision on an SCK or chip-select edge therefore shows at the outputs about three system clocks after the pin moves, and a busy cycle starts the same number of clocks after chip select rises. The bench holds each SCK phase for eight system clocks and samples SO and `so_oe` on the falling system clock just before it raises SCK, so the bit after the preceding SCK fall has settled by then. Busy is checked through a status read issued straight after the write frame, well inside the programming window. The idle state is checked after waiting WR_CYCLES plus a margin.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned CNT_W  = 4;

    localparam logic [7:0] OP_SETWEL = 8'h06;
    localparam logic [7:0] OP_CLRWEL = 8'h04;
    localparam logic [7:0] OP_STRD   = 8'h05;
    localparam logic [7:0] OP_STWR   = 8'h01;

    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_RADDR, S_WADDR, S_RDATA,
        S_WDATA, S_SDATA, S_STAT, S_IGN
    } fsm_e;

    typedef struct packed {
        fsm_e              st;
        logic              cs_p;
        logic              sck_p;
        logic [CNT_W-1:0]  bitcnt;
        logic [DATA_W-1:0] sh_in;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] out_sr;
        logic [2:0]        ocnt;
        logic              so_bit;
        logic              so_oe;
        logic              wel;
        logic [1:0]        bp;
    } ctl_t;

    function automatic logic in_locked_range(input logic [1:0] bp,
                                             input logic [ADDR_W-1:0] a);
        unique case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] s
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    generate
        for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else if (g == 0) pipe_q[g] <= d;
                else pipe_q[g] <= pipe_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign s = pipe_q[STAGES-1];
endmodule

// File: rtl/ee_prog_timer.sv
module ee_prog_timer #(
    parameter int unsigned CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1)) && !start;
endmodule

// File: rtl/ee_array.sv
module ee_array #(
    parameter int unsigned AW = 9,
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] ERASED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) cell_q[i] <= ERASED;
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
    import spi_ee_pkg::*;
#(
    parameter int unsigned WR_CYCLES   = 500000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);
    localparam int unsigned NPIN = 4;

    logic [NPIN-1:0] pin_s;
    logic cs_s, sck_s, si_s, wp_s;

    ee_pin_sync #(
        .W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .d({wp_n, si, sck, cs_n}), .s(pin_s)
    );

    assign cs_s  = pin_s[0];
    assign sck_s = pin_s[1];
    assign si_s  = pin_s[2];
    assign wp_s  = pin_s[3];

    ctl_t q, n;

    logic              tmr_start, busy, tmr_done;
    logic              mem_we;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    ee_prog_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .busy(busy), .done(tmr_done)
    );

    ee_array #(.AW(ADDR_W), .DW(DATA_W), .ERASED(8'hFF)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(q.addr), .wdata(q.sh_in),
        .raddr(rd_addr), .rdata(rd_data)
    );

    logic cs_rise, cs_fall, sck_rise, sck_fall;
    logic [7:0] op_w;
    logic [7:0] status_w;
    logic       is_read_op, is_write_op, commit_ok;

    assign cs_rise  =  cs_s & ~q.cs_p;
    assign cs_fall  = ~cs_s &  q.cs_p;
    assign sck_rise = ~cs_s &  sck_s & ~q.sck_p;
    assign sck_fall = ~cs_s & ~sck_s &  q.sck_p;
    assign op_w     = {q.sh_in[6:0], si_s};
    assign status_w = {4'b0000, q.bp, q.wel, busy};

    assign is_read_op  = (op_w[7:4] == 4'h0) && (op_w[2:0] == 3'b011);
    assign is_write_op = (op_w[7:4] == 4'h0) && (op_w[2:0] == 3'b010);

    assign commit_ok = ((q.st == S_WDATA) || (q.st == S_SDATA))
                     && (q.bitcnt == CNT_W'(8)) && q.wel && wp_s && !busy
                     && ((q.st == S_SDATA) || !in_locked_range(q.bp, q.addr));

    always_comb begin
        if (q.st == S_RADDR) rd_addr = {q.addr[ADDR_W-1], op_w};
        else                 rd_addr = q.addr + ADDR_W'(1);
    end

    always_comb begin
        n         = q;
        mem_we    = 1'b0;
        tmr_start = 1'b0;
        n.cs_p    = cs_s;
        n.sck_p   = sck_s;
        if (tmr_done) n.wel = 1'b0;

        if (cs_rise) begin
            n.st    = S_IDLE;
            n.so_oe = 1'b0;
            if (commit_ok) begin
                tmr_start = 1'b1;
                if (q.st == S_WDATA) mem_we = 1'b1;
                else                 n.bp   = q.sh_in[3:2];
            end
        end else if (cs_fall) begin
            n.st     = S_OPC;
            n.bitcnt = '0;
            n.so_oe  = 1'b0;
        end else if (sck_rise) begin
            n.sh_in = op_w;
            case (q.st)
                S_OPC: begin
                    if (q.bitcnt == CNT_W'(7)) begin
                        n.bitcnt = '0;
                        if (busy && (op_w != OP_STRD)) begin
                            n.st = S_IGN;
                        end else if (op_w == OP_SETWEL) begin
                            n.wel = 1'b1;
                            n.st  = S_IGN;
                        end else if (op_w == OP_CLRWEL) begin
                            n.wel = 1'b0;
                            n.st  = S_IGN;
                        end else if (op_w == OP_STRD) begin
                            n.out_sr = status_w;
                            n.ocnt   = '0;
                            n.st     = S_STAT;
                        end else if (op_w == OP_STWR) begin
                            n.st = S_SDATA;
                        end else if (is_read_op) begin
                            n.addr[ADDR_W-1] = op_w[3];
                            n.st             = S_RADDR;
                        end else if (is_write_op) begin
                            n.addr[ADDR_W-1] = op_w[3];
                            n.st             = S_WADDR;
                        end else begin
                            n.st = S_IGN;
                        end
                    end else begin
                        n.bitcnt = q.bitcnt + 1'b1;
                    end
                end
                S_RADDR, S_WADDR: begin
                    if (q.bitcnt == CNT_W'(7)) begin
                        n.bitcnt     = '0;
                        n.addr[7:0]  = op_w;
                        if (q.st == S_RADDR) begin
                            n.out_sr = rd_data;
                            n.ocnt   = '0;
                            n.st     = S_RDATA;
                        end else begin
                            n.st = S_WDATA;
                        end
                    end else begin
                        n.bitcnt = q.bitcnt + 1'b1;
                    end
                end
                S_WDATA, S_SDATA: begin
                    if (q.bitcnt != CNT_W'(9)) n.bitcnt = q.bitcnt + 1'b1;
                end
                default: ;
            endcase
        end else if (sck_fall && ((q.st == S_RDATA) || (q.st == S_STAT))) begin
            n.so_oe  = 1'b1;
            n.so_bit = q.out_sr[7];
            n.out_sr = {q.out_sr[6:0], 1'b0};
            n.ocnt   = q.ocnt + 3'd1;
            if (q.ocnt == 3'd7) begin
                if (q.st == S_RDATA) begin
                    n.addr   = q.addr + ADDR_W'(1);
                    n.out_sr = rd_data;
                end else begin
                    n.out_sr = status_w;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_IDLE;
            q.cs_p   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    logic              wel_q;
    logic [1:0]        bp_q;
    logic [ADDR_W-1:0] wr_addr;

    assign wel_q   = q.wel;
    assign bp_q    = q.bp;
    assign wr_addr = q.addr;
    assign so      = q.so_bit;
    assign so_oe   = q.so_oe;
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_s,
    input logic       wp_s,
    input logic       so_oe,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       mem_we,
    input logic [8:0] waddr
);
    // R6
    busy_end_wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R2
    start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R7
    start_needs_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wp_s));

    // R9
    start_on_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_s) && !$past(cs_s, 2)));

    // R10
    no_store_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);

    // R8
    store_outside_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !((bp == 2'b11) || ((bp == 2'b10) && waddr[8])
                     || ((bp == 2'b01) && (waddr[8:7] == 2'b11))));

    // R11
    so_released_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !so_oe);
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .wp_s(wp_s), .so_oe(so_oe),
    .busy(busy), .wel(wel_q), .bp(bp_q), .mem_we(mem_we), .waddr(wr_addr)
);

// File: tb/test_spi_eeprom_ctrl.sv
module test_spi_eeprom_ctrl;
    localparam int HP   = 8;
    localparam int WCYC = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
    logic so, so_oe;

    int total = 0, bad = 0;
    logic [7:0] ref_mem [512];
    logic ref_wel = 1'b0, ref_busy = 1'b0;
    logic [1:0] ref_bp = 2'b00;

    always #5 clk = ~clk;

    spi_eeprom_ctrl #(.WR_CYCLES(WCYC), .SYNC_STAGES(2)) i_spi_eeprom_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .so(so), .so_oe(so_oe)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit fenced(input int a);
        case (ref_bp)
            2'b01:   return a >= 'h180;
            2'b10:   return a >= 'h100;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic bit_io(input logic b, output logic r, output logic oe);
        si = b;
        tick(HP);
        r  = so;
        oe = so_oe;
        sck = 1'b1;
        tick(HP);
        sck = 1'b0;
    endtask

    task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx, output logic any_oe);
        logic r, oe;
        any_oe = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bit_io(tx[i], r, oe);
            rx[i] = r;
            any_oe |= oe;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic desel();
        tick(HP);
        cs_n = 1'b1;
        tick(2*HP);
        // R11: released after deselect
        chk(so_oe == 1'b0, "R11 idle", so_oe, 0);
    endtask

    task automatic send_op(input logic [7:0] op);
        logic [7:0] rx; logic oe;
        sel();
        byte_io(op, rx, oe);
        desel();
        if (!ref_busy) begin
            if (op == 8'h06) ref_wel = 1'b1;
            if (op == 8'h04) ref_wel = 1'b0;
        end
    endtask

    task automatic status_chk(input string tag);
        logic [7:0] rx, st; logic oe;
        sel();
        byte_io(8'h05, rx, oe);
        chk(oe == 1'b0, "R11 opcode", oe, 0);
        byte_io(8'hA5, st, oe);
        desel();
        chk(st == {4'b0, ref_bp, ref_wel, ref_busy}, tag, st, {4'b0, ref_bp, ref_wel, ref_busy});
    endtask

    task automatic write_frame(input logic [7:0] op_base, input int addr,
                               input logic [7:0] data, input int nbits);
        logic [7:0] rx; logic r, oe;
        logic [8:0] a9;
        logic ok;
        a9 = 9'(addr);
        sel();
        if (op_base == 8'h02) begin
            byte_io(8'h02 | {4'b0, a9[8], 3'b0}, rx, oe);
            byte_io(a9[7:0], rx, oe);
        end else begin
            byte_io(8'h01, rx, oe);
        end
        for (int i = 0; i < nbits; i++) bit_io((i < 8) ? data[7-i] : 1'b0, r, oe);
        desel();
        ok = ref_wel && wp_n && !ref_busy && (nbits == 8);
        if (op_base == 8'h02) ok = ok && !fenced(addr);
        if (ok) begin
            if (op_base == 8'h02) ref_mem[addr] = data;
            else ref_bp = data[3:2];
            ref_busy = 1'b1;
        end
    endtask

    task automatic read_chk(input int addr, input int nbytes, input string tag);
        logic [7:0] rx; logic oe;
        logic [8:0] a9;
        a9 = 9'(addr);
        sel();
        byte_io(8'h03 | {4'b0, a9[8], 3'b0}, rx, oe);
        byte_io(a9[7:0], rx, oe);
        // R11: no drive during address
        chk(oe == 1'b0, "R11 address", oe, 0);
        for (int k = 0; k < nbytes; k++) begin
            byte_io(8'h00, rx, oe);
            if (ref_busy) chk(oe == 1'b0, tag, oe, 0);
            else chk(rx == ref_mem[(addr + k) % 512], tag, rx, ref_mem[(addr + k) % 512]);
        end
        desel();
    endtask

    task automatic wait_cycle();
        tick(WCYC + 100);
        if (ref_busy) begin
            ref_busy = 1'b0;
            ref_wel  = 1'b0;
        end
    endtask

    initial begin
        tick(200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rx, s0, s1; logic oe;
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'hFF;
        tick(5);
        // R1: reset state
        chk(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
        rst_n = 1'b1;
        tick(5);
        status_chk("R1 status");
        read_chk(0, 1, "R1 erased");
        read_chk('h1FF, 1, "R1 erased top");

        // R2: refused without latch
        write_frame(8'h02, 'h005, 8'h11, 8);
        status_chk("R2 no busy");
        read_chk('h005, 1, "R2 unchanged");
        write_frame(8'h01, 0, 8'h0C, 8);
        status_chk("R2 status write refused");

        // R3
        send_op(8'h06);
        status_chk("R3 latch set");
        send_op(8'h04);
        status_chk("R3 latch clear");

        // R4, R6, R10
        send_op(8'h06);
        write_frame(8'h02, 'h1A5, 8'h3C, 8);
        status_chk("R6 busy shown");
        read_chk('h1A5, 1, "R10 read ignored");
        write_frame(8'h02, 'h010, 8'h77, 8);
        send_op(8'h04);
        status_chk("R10 latch op ignored");
        wait_cycle();
        status_chk("R6 busy and latch cleared");
        read_chk('h1A5, 1, "R4 read back");
        read_chk('h010, 1, "R10 write ignored");

        // R12: wrap
        send_op(8'h06); write_frame(8'h02, 'h1FF, 8'hA1, 8); wait_cycle();
        send_op(8'h06); write_frame(8'h02, 'h000, 8'h5B, 8); wait_cycle();
        read_chk('h1FE, 3, "R12 sequential wrap");

        // R5: repeated status bytes
        send_op(8'h06);
        sel();
        byte_io(8'h05, rx, oe);
        byte_io(8'hFF, s0, oe);
        byte_io(8'h00, s1, oe);
        desel();
        chk(s0 == 8'h02, "R5 first byte", s0, 8'h02);
        chk(s1 == 8'h02, "R5 repeat byte", s1, 8'h02);

        // R7
        wp_n = 1'b0;
        tick(4);
        write_frame(8'h02, 'h020, 8'h42, 8);
        status_chk("R7 array write refused");
        write_frame(8'h01, 0, 8'h0C, 8);
        status_chk("R7 status write refused");
        read_chk('h020, 1, "R7 memory unchanged");
        wp_n = 1'b1;
        tick(4);

        // R8
        write_frame(8'h01, 0, 8'h04, 8); wait_cycle();
        status_chk("R8 field 01");
        send_op(8'h06); write_frame(8'h02, 'h180, 8'h12, 8);
        status_chk("R8 0x180 refused");
        write_frame(8'h02, 'h17F, 8'h99, 8); wait_cycle();
        read_chk('h17F, 2, "R8 below fence");
        send_op(8'h06); write_frame(8'h01, 0, 8'h08, 8); wait_cycle();
        send_op(8'h06); write_frame(8'h02, 'h100, 8'h34, 8);
        status_chk("R8 0x100 refused");
        write_frame(8'h02, 'h0FF, 8'h66, 8); wait_cycle();
        read_chk('h0FF, 2, "R8 field 10");
        send_op(8'h06); write_frame(8'h01, 0, 8'h0C, 8); wait_cycle();
        send_op(8'h06); write_frame(8'h02, 'h000, 8'h56, 8);
        status_chk("R8 all fenced");
        read_chk('h000, 1, "R8 0x000 kept");
        write_frame(8'h01, 0, 8'h00, 8); wait_cycle();
        status_chk("R8 field cleared");

        // R9
        send_op(8'h06);
        write_frame(8'h02, 'h040, 8'hC3, 7);
        status_chk("R9 seven bits");
        write_frame(8'h02, 'h040, 8'hC3, 9);
        status_chk("R9 nine bits");
        read_chk('h040, 1, "R9 nothing stored");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule